// File: doc/BRIEF.md
# Predicated Multi-Register Word Load Sequencer

This block carries out one decoded load of 32-bit words into a group of two or four consecutive vector registers. A single count-style predicate value controls the whole group. The sequencer works out the start address from a 64-bit base and a 64-bit index scaled by four. It then visits every element slot in order. For active slots it issues one single-word read at a time on a simple memory port. For inactive slots it writes zero and reads nothing.

The address advances four bytes for every slot, whether the slot is active or not. The assembled registers are kept in the block until the last slot has been handled. Only then are they written to the vector register file, one register per cycle. A read error, or a misaligned stack-pointer base, abandons the operation without touching any destination register and raises a fault pulse.

The predicate register number is presented to the predicate file on `pred_sel` during the start cycle, and its contents are sampled from `pred_val` in that same cycle.

Top module: `mvec_load_seq`

## Requirements
- R1: The first destination register is `{dst_field,1'b0}` when `grp4`=0 (two registers), and `{dst_field[3:1],2'b00}` when `grp4`=1 (four registers, `dst_field[0]` ignored). The registers are written in ascending order, one per cycle, with each `rf_addr` one above the previous.
- R2: `pred_sel` equals `{1'b1,pred_field}`. `pred_val` is sampled in the cycle `start` is accepted.
- R3: The start address is `base_val + 4*index_val`. Slot s (counted across the whole group) uses address start + 4*s, so inactive slots still advance the address.
- R4: The count K is `pred_val[4:0]`, saturated to the slot total (8 or 16). With `pred_val[15]`=0 the first K slots are active. With `pred_val[15]`=1 the last K slots are active.
- R5: An inactive slot issues no memory read and its element is zero.
- R6: Element e of group register r holds the data read for slot r*4+e, in `rf_data[32e+31:32e]`.
- R7: No register is written before every slot has been handled. The writes occupy consecutive cycles, and `done` is high only together with the final write.
- R8: A response with `mem_rerr`=1 ends the operation: `fault` pulses for one cycle, `busy` drops, and no register write or `done` occurs.
- R9: With `sp_sel`=1 and `base_val[3:0]`≠0, `fault` pulses in the cycle after start. No read and no write take place.
- R10: The cycle count from start to `done` is the sum over slots of 1 for an inactive slot, plus (1 + response latency) for an active slot, plus the number of registers. It never depends on the loaded data.
- R11: `mem_req` is a one-cycle pulse with at most one read outstanding. `busy` is high from the cycle after start until `done` or `fault`.
- R12: After reset `busy`, `mem_req`, `rf_we`, `done` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a request when idle |
| grp4 | input | 1 | 1: four registers, 0: two registers |
| dst_field | input | 4 | Destination register field |
| pred_field | input | 3 | Predicate register field |
| pred_sel | output | 4 | Predicate register number to read |
| pred_val | input | 16 | Low 16 bits of the selected predicate |
| sp_sel | input | 1 | Base is the stack pointer (alignment checked) |
| base_val | input | 64 | Base address value |
| index_val | input | 64 | Element index value |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Single-word read request pulse |
| mem_addr | output | 64 | Read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response error |
| rf_we | output | 1 | Vector register write enable |
| rf_addr | output | 5 | Vector register number |
| rf_data | output | 128 | Vector register write data |
| done | output | 1 | Completion pulse with the final write |
| fault | output | 1 | Abort pulse |

## Verification
The assertions take for granted that `start` is raised only while `busy` is low. They also assume that `mem_rvalid` arrives exactly once for each request and never while no read is outstanding. The bench keeps to this by issuing one request at a time from a task that waits for `done` or `fault`. A memory model answers each captured request after a fixed latency and raises nothing unsolicited.

// File: rtl/mvec_load_seq.sv
module mvec_load_seq #(
  parameter int VL = 128,
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          grp4,
  input  logic [3:0]    dst_field,
  input  logic [2:0]    pred_field,
  output logic [3:0]    pred_sel,
  input  logic [15:0]   pred_val,
  input  logic          sp_sel,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_rerr,
  output logic          rf_we,
  output logic [4:0]    rf_addr,
  output logic [VL-1:0] rf_data,
  output logic          done,
  output logic          fault
);
  localparam int ELEMS = VL / 32;
  localparam int MAXS  = 4 * ELEMS;
  localparam int SW    = $clog2(MAXS);
  localparam int EW    = $clog2(ELEMS);

  typedef enum logic [1:0] {S_IDLE, S_SLOT, S_WAIT, S_WRITE} state_t;
  state_t state;

  logic [SW:0]   slot, total_q, kk_q;
  logic          inv_q, grp4_q, fault_q;
  logic [4:0]    first_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    wr_idx;
  logic [31:0]   elem [MAXS];

  wire [SW:0] cnt_in   = pred_val[SW:0];
  wire [SW:0] total_in = grp4 ? (SW+1)'(MAXS) : (SW+1)'(MAXS/2);
  wire        misalign = sp_sel && (base_val[3:0] != 4'd0);
  wire        active   = inv_q ? (slot >= total_q - kk_q) : (slot < kk_q);
  wire        last_slot = (slot == total_q - 1'b1);
  wire        last_wr   = (wr_idx == (grp4_q ? 2'd3 : 2'd1));
  wire [SW-1:0] rbase   = SW'(wr_idx) << EW;

  assign pred_sel = {1'b1, pred_field};
  assign busy     = (state != S_IDLE);
  assign mem_req  = (state == S_SLOT) && active;
  assign mem_addr = addr_q;
  assign rf_we    = (state == S_WRITE);
  assign rf_addr  = first_q + 5'(wr_idx);
  assign done     = rf_we && last_wr;
  assign fault    = fault_q;

  for (genvar e = 0; e < ELEMS; e++) begin : g_pack
    assign rf_data[32*e +: 32] = elem[rbase + SW'(e)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      slot    <= '0;
      total_q <= '0;
      kk_q    <= '0;
      inv_q   <= 1'b0;
      grp4_q  <= 1'b0;
      first_q <= '0;
      addr_q  <= '0;
      wr_idx  <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (misalign) begin
            fault_q <= 1'b1;
          end else begin
            state   <= S_SLOT;
            slot    <= '0;
            wr_idx  <= '0;
            total_q <= total_in;
            kk_q    <= (cnt_in > total_in) ? total_in : cnt_in;
            inv_q   <= pred_val[15];
            grp4_q  <= grp4;
            first_q <= grp4 ? {dst_field[3:1], 2'b00} : {dst_field, 1'b0};
            addr_q  <= base_val + (index_val << 2);
          end
        end
        S_SLOT: if (active) begin
          state <= S_WAIT;
        end else begin
          addr_q <= addr_q + AW'(4);
          slot   <= slot + 1'b1;
          if (last_slot) state <= S_WRITE;
        end
        S_WAIT: if (mem_rvalid) begin
          if (mem_rerr) begin
            fault_q <= 1'b1;
            state   <= S_IDLE;
          end else begin
            addr_q <= addr_q + AW'(4);
            slot   <= slot + 1'b1;
            state  <= last_slot ? S_WRITE : S_SLOT;
          end
        end
        S_WRITE: begin
          wr_idx <= wr_idx + 1'b1;
          if (last_wr) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_SLOT && !active)
      elem[slot[SW-1:0]] <= 32'd0;
    else if (state == S_WAIT && mem_rvalid && !mem_rerr)
      elem[slot[SW-1:0]] <= mem_rdata;
  end
endmodule

module mvec_load_seq_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          sp_sel,
  input logic [AW-1:0] base_val,
  input logic          busy,
  input logic          mem_req,
  input logic          rf_we,
  input logic [4:0]    rf_addr,
  input logic          done,
  input logic          fault
);
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R11
  AST_DONE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rf_we); // R7
  AST_NO_REQ_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !mem_req); // R7
  AST_WRITE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !done) |=> (rf_we && rf_addr == $past(rf_addr) + 5'd1)); // R1
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!rf_we && !done && !mem_req)); // R8
  AST_SP_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && sp_sel && base_val[3:0] != 4'd0) |=> (fault && !busy)); // R9
endmodule

bind mvec_load_seq mvec_load_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sp_sel(sp_sel), .base_val(base_val),
  .busy(busy), .mem_req(mem_req), .rf_we(rf_we), .rf_addr(rf_addr),
  .done(done), .fault(fault)
);

// File: tb/test_mvec_load_seq.sv
`timescale 1ns/1ps
module test_mvec_load_seq;
  localparam int VL = 128;
  localparam int E  = VL / 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, grp4 = 0, sp_sel = 0;
  logic [3:0] dst_field = 0;
  logic [2:0] pred_field = 0;
  logic [15:0] pred_val = 0;
  logic [63:0] base_val = 0, index_val = 0;
  logic mem_rvalid = 0, mem_rerr = 0;
  logic [31:0] mem_rdata = 0;
  wire [3:0] pred_sel;
  wire busy, mem_req, rf_we, done, fault;
  wire [63:0] mem_addr;
  wire [4:0] rf_addr;
  wire [VL-1:0] rf_data;

  always #2 clk = ~clk;

  mvec_load_seq #(.VL(VL), .AW(64)) i_mvec_load_seq (.*);

  int checks = 0, fails = 0;
  int wr_cnt, req_cnt, cycles, done_cnt, fault_cnt;
  logic [4:0] wr_addr [8];
  logic [VL-1:0] wr_data [8];
  logic [63:0] req_addr [32];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dfn(input logic [63:0] a, input logic [31:0] seed);
    return a[31:0] ^ seed ^ 32'h5a5a_0000;
  endfunction

  function automatic bit is_act(input int s, input int tot, input int cnt, input bit inv);
    int k = (cnt > tot) ? tot : cnt;
    return inv ? (s >= tot - k) : (s < k);
  endfunction

  task automatic run_op(input bit g4, input logic [3:0] dst, input logic [2:0] pf,
                        input logic [15:0] pv, input bit sp, input logic [63:0] b,
                        input logic [63:0] ix, input int lat, input int err_at,
                        input logic [31:0] seed);
    int pend = 0;
    int rq = 0;
    logic [63:0] pa = 0;
    wr_cnt = 0; req_cnt = 0; cycles = 0; done_cnt = 0; fault_cnt = 0;
    @(negedge clk);
    grp4 = g4; dst_field = dst; pred_field = pf; pred_val = pv;
    sp_sel = sp; base_val = b; index_val = ix; start = 1;
    #1;
    chk(pred_sel == {1'b1, pf}, "R2 pred_sel", 128'(pred_sel), 128'({1'b1, pf}));
    @(negedge clk);
    start = 0; pred_val = 16'hffff;
    for (int c = 0; c < 600; c++) begin
      cycles++;
      mem_rvalid = 0; mem_rerr = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rvalid = 1;
          mem_rdata = dfn(pa, seed);
          mem_rerr = (rq == err_at);
          rq++;
        end
      end
      if (mem_req) begin
        if (req_cnt < 32) req_addr[req_cnt] = mem_addr;
        req_cnt++; pa = mem_addr; pend = lat;
      end
      if (rf_we) begin
        if (wr_cnt < 8) begin wr_addr[wr_cnt] = rf_addr; wr_data[wr_cnt] = rf_data; end
        wr_cnt++;
      end
      if (done) done_cnt++;
      if (fault) fault_cnt++;
      if (done || fault) break;
      @(negedge clk);
      if (c == 599) chk(0, "R11 operation hung", 0, 1);
    end
    mem_rvalid = 0; mem_rerr = 0;
    @(negedge clk);
    chk(!busy, "R11 busy after end", 128'(busy), 0);
  endtask

  task automatic verify(input string tag, input bit g4, input logic [3:0] dst,
                        input logic [15:0] pv, input logic [63:0] b,
                        input logic [63:0] ix, input int lat, input logic [31:0] seed);
    int nreg = g4 ? 4 : 2;
    int tot = nreg * E;
    int ecyc = nreg;
    int ereq = 0;
    logic [4:0] first = g4 ? {dst[3:1], 2'b00} : {dst, 1'b0};
    logic [63:0] a0 = b + (ix << 2);
    chk(done_cnt == 1 && fault_cnt == 0, {tag, " R7 done once"}, 128'(done_cnt), 1);
    chk(wr_cnt == nreg, {tag, " R7 write count"}, 128'(wr_cnt), 128'(nreg));
    for (int r = 0; r < nreg; r++) begin
      logic [VL-1:0] ev = '0;
      for (int e = 0; e < E; e++) begin
        int s = r * E + e;
        logic [63:0] a = a0 + 64'(4 * s);
        if (is_act(s, tot, int'(pv[4:0]), pv[15])) begin
          ev[32*e +: 32] = dfn(a, seed);
          if (ereq < 32 && ereq < req_cnt)
            chk(req_addr[ereq] == a, {tag, " R3 read address"}, 128'(req_addr[ereq]), 128'(a));
          ereq++; ecyc += 1 + lat;
        end else begin
          ecyc += 1;
        end
      end
      chk(wr_addr[r] == first + 5'(r), {tag, " R1 register number"}, 128'(wr_addr[r]), 128'(first + 5'(r)));
      chk(wr_data[r] == ev, {tag, " R6 R5 register data"}, 128'(wr_data[r]), 128'(ev));
    end
    chk(req_cnt == ereq, {tag, " R4 R5 read count"}, 128'(req_cnt), 128'(ereq));
    chk(cycles == ecyc, {tag, " R10 cycle count"}, 128'(cycles), 128'(ecyc));
  endtask

  task automatic t_reset;
    chk(!busy && !mem_req && !rf_we && !done && !fault, "R12 reset outputs",
        128'({busy, mem_req, rf_we, done, fault}), 0);
  endtask

  task automatic t_two_full;
    run_op(0, 4'd3, 3'd2, 16'h0008, 0, 64'h1000, 64'd5, 1, -1, 32'h1111);
    verify("two_full", 0, 4'd3, 16'h0008, 64'h1000, 64'd5, 1, 32'h1111);
  endtask

  task automatic t_four_partial;
    run_op(1, 4'b1011, 3'd5, 16'h0005, 0, 64'h2003, 64'd2, 2, -1, 32'h2222);
    verify("four_partial", 1, 4'b1011, 16'h0005, 64'h2003, 64'd2, 2, 32'h2222);
  endtask

  task automatic t_invert;
    run_op(0, 4'd0, 3'd7, 16'h8003, 0, 64'h3000, 64'd0, 1, -1, 32'h3333);
    verify("invert", 0, 4'd0, 16'h8003, 64'h3000, 64'd0, 1, 32'h3333);
    chk(req_addr[0] == 64'h3014, "R3 R4 first active after skips", 128'(req_addr[0]), 128'h3014);
  endtask

  task automatic t_invert_four;
    run_op(1, 4'd4, 3'd1, 16'h800a, 0, 64'h7000, 64'd1, 3, -1, 32'h7777);
    verify("invert_four", 1, 4'd4, 16'h800a, 64'h7000, 64'd1, 3, 32'h7777);
  endtask

  task automatic t_none_active;
    run_op(1, 4'd8, 3'd0, 16'h0000, 0, 64'h4000, 64'd9, 1, -1, 32'h4444);
    verify("none", 1, 4'd8, 16'h0000, 64'h4000, 64'd9, 1, 32'h4444);
  endtask

  task automatic t_saturate;
    run_op(0, 4'd9, 3'd3, 16'h001f, 0, 64'h5000, 64'd3, 1, -1, 32'h5555);
    verify("saturate", 0, 4'd9, 16'h001f, 64'h5000, 64'd3, 1, 32'h5555);
  endtask

  task automatic t_sp;
    run_op(0, 4'd1, 3'd0, 16'h0004, 1, 64'h6008, 64'd0, 1, -1, 32'h6666);
    chk(fault_cnt == 1, "R9 misaligned sp fault", 128'(fault_cnt), 1);
    chk(cycles == 1, "R9 fault cycle after start", 128'(cycles), 1);
    chk(req_cnt == 0 && wr_cnt == 0, "R9 no access", 128'({req_cnt, wr_cnt}), 0);
    run_op(0, 4'd1, 3'd0, 16'h0004, 1, 64'h6010, 64'd0, 1, -1, 32'h6666);
    verify("sp_aligned", 0, 4'd1, 16'h0004, 64'h6010, 64'd0, 1, 32'h6666);
  endtask

  task automatic t_rerr;
    run_op(1, 4'd0, 3'd0, 16'h0006, 0, 64'h8000, 64'd0, 1, 1, 32'h8888);
    chk(fault_cnt == 1 && done_cnt == 0, "R8 error fault", 128'({fault_cnt, done_cnt}), 128'({32'd1, 32'd0}));
    chk(wr_cnt == 0, "R8 no register write", 128'(wr_cnt), 0);
    chk(req_cnt == 2, "R8 reads stop at error", 128'(req_cnt), 2);
  endtask

  task automatic t_timing;
    int c1;
    run_op(0, 4'd2, 3'd0, 16'h0005, 0, 64'h9000, 64'd0, 2, -1, 32'h0000_0000);
    c1 = cycles;
    run_op(0, 4'd2, 3'd0, 16'h0005, 0, 64'h9000, 64'd0, 2, -1, 32'hffff_ffff);
    chk(cycles == c1, "R10 data-independent cycles", 128'(cycles), 128'(c1));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_two_full();
    t_four_partial();
    t_invert();
    t_invert_four();
    t_none_active();
    t_saturate();
    t_sp();
    t_rerr();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule